// File: doc/BRIEF.md
# Lock-Aware Round-Robin Victim Selector

This block picks the way to evict when a set-associative cache misses. A single replacement pointer serves every set of the cache. On a miss, the block starts at the pointer and searches upward, wrapping past the top way. It takes the first way that is neither locked in the addressed set nor barred from allocation for the kind of access that missed. Instruction fetches and data accesses each have their own allocation-disable mask.

The search finishes in the same cycle as the miss request. The answer comes back as a way index with a valid flag, or as a flag saying no way can take the line. Once the miss is accepted, the pointer rests on the chosen way. It moves to the next way only when the fill controller reports a fill that completed cleanly. If the fill ends in an error, the pointer stays put, so the same way is offered again on the next miss. The line fill, the tag arrays and the logic that sets locks all sit outside this block.

Top module: `lockaware_victim_sel`

## Requirements
- R1: One replacement pointer is shared by all sets. It resets to way 0, so the first miss after reset with every way eligible selects way 0.
- R2: The victim is the first eligible way found by starting at the effective start way and counting upward. The search wraps from way NUM_WAYS-1 to way 0.
- R3: A way is eligible only if its `set_lock` bit is 0 and its bit in the disable mask for the missing access is 0. `insn_alloc_dis` applies when `miss_is_data` is 0 and `data_alloc_dis` applies when `miss_is_data` is 1. Bit i of each vector refers to way i.
- R4: When no way is eligible on a miss, `none_avail` is 1 and `victim_vld` is 0. The pointer keeps its value, apart from the fill advance described in R8.
- R5: When a miss finds a victim, the pointer takes the victim's index at the next clock edge.
- R6: A cycle with `fill_done`=1 and `fill_err`=0 advances the pointer by one way. The pointer wraps from NUM_WAYS-1 to 0.
- R7: A cycle with `fill_done`=1 and `fill_err`=1 leaves the pointer unchanged, so the next miss with the same eligibility selects the same way.
- R8: When a clean fill completion and a miss arrive in the same cycle, the advance is applied first. The search for that miss starts at pointer+1 (wrapped).
- R9: `victim_vld`, `none_avail` and `victim_way` are combinational in the miss cycle. Both flags are 0 whenever `miss_req` is 0, and the two flags are never 1 together.
- R10: `fill_err` has no effect while `fill_done` is 0.
- R11: NUM_WAYS is 4 or 8. The way index is clog2(NUM_WAYS) bits wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| miss_req | input | 1 | A miss needs a victim this cycle |
| miss_is_data | input | 1 | 1 = data access missed, 0 = instruction fetch missed |
| insn_alloc_dis | input | NUM_WAYS | Ways barred from allocation by instruction misses |
| data_alloc_dis | input | NUM_WAYS | Ways barred from allocation by data misses |
| set_lock | input | NUM_WAYS | Lock bits of the addressed set |
| fill_done | input | 1 | The line fill of the last victim has ended |
| fill_err | input | 1 | The ending fill failed (qualified by fill_done) |
| victim_way | output | clog2(NUM_WAYS) | Index of the chosen victim way |
| victim_vld | output | 1 | victim_way is valid for this miss |
| none_avail | output | 1 | No way is eligible for this miss |

## Verification
The assertions check on every cycle that a reported victim is unlocked and allowed for the access type, that a no-way result only appears with an empty eligibility mask, and that both flags stay low without a request. They also check that the pointer lands on an accepted victim, steps by one with wrap on a clean fill, and holds otherwise. Only the bench's scenarios can show that the search takes the nearest eligible way going upward from the pointer. The same holds for three timing rules: reset leaves the pointer at way 0, an errored fill replays the same way, and a fill that coincides with a miss shifts the search start first. The bench observes these through the victim chosen on later misses.

// File: rtl/lvs_pkg.sv
package lvs_pkg;

  // Largest supported associativity; the way index fits in 3 bits.
  localparam int unsigned LVS_MAX_WAYS = 8;
  localparam int unsigned LVS_MAX_IDXW = 3;

  typedef enum logic {
    ACC_INSN = 1'b0,
    ACC_DATA = 1'b1
  } acc_kind_e;

  // Next way in round-robin order among n ways.
  function automatic logic [LVS_MAX_IDXW-1:0] way_step(
    input logic [LVS_MAX_IDXW-1:0] cur,
    input int unsigned             n
  );
    if (int'(cur) >= int'(n) - 1) return '0;
    return cur + 3'd1;
  endfunction

  // A way may take the line when it is neither locked nor disabled for the access.
  function automatic logic [LVS_MAX_WAYS-1:0] allowed_ways(
    input logic [LVS_MAX_WAYS-1:0] dis,
    input logic [LVS_MAX_WAYS-1:0] lock
  );
    return ~(dis | lock);
  endfunction

endpackage

// File: rtl/lvs_elig.sv
module lvs_elig
  import lvs_pkg::*;
#(
  parameter int unsigned NUM_WAYS = 4
) (
  input  acc_kind_e             kind,
  input  logic [NUM_WAYS-1:0]   insn_dis,
  input  logic [NUM_WAYS-1:0]   data_dis,
  input  logic [NUM_WAYS-1:0]   lock,
  output logic [NUM_WAYS-1:0]   elig
);

  logic [NUM_WAYS-1:0]     dis_sel;
  logic [LVS_MAX_WAYS-1:0] wide;

  // R3: pick the disable mask by access type, then strip locked ways.
  always_comb begin
    dis_sel = (kind == ACC_DATA) ? data_dis : insn_dis;
    wide    = allowed_ways(LVS_MAX_WAYS'(dis_sel), LVS_MAX_WAYS'(lock));
    elig    = wide[NUM_WAYS-1:0];
  end

endmodule

// File: rtl/lvs_search.sv
module lvs_search #(
  parameter int unsigned NUM_WAYS = 4,
  localparam int unsigned IDXW    = $clog2(NUM_WAYS)
) (
  input  logic [NUM_WAYS-1:0] elig,
  input  logic [IDXW-1:0]     start,
  output logic                found,
  output logic [IDXW-1:0]     way
);

  // R2: rotating priority search; walk down so the nearest hit from start wins.
  always_comb begin
    found = 1'b0;
    way   = '0;
    for (int i = NUM_WAYS - 1; i >= 0; i--) begin
      int j;
      j = (int'(start) + i) % int'(NUM_WAYS);
      if (elig[j]) begin
        found = 1'b1;
        way   = IDXW'(j);
      end
    end
  end

endmodule

// File: rtl/lvs_ptr.sv
module lvs_ptr
  import lvs_pkg::*;
#(
  parameter int unsigned NUM_WAYS = 4,
  localparam int unsigned IDXW    = $clog2(NUM_WAYS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            fill_ok,
  input  logic            accept,
  input  logic [IDXW-1:0] sel,
  output logic [IDXW-1:0] ptr,
  output logic [IDXW-1:0] start
);

  logic [LVS_MAX_IDXW-1:0] stepped;

  // R6/R8: a clean fill moves the start of this cycle's search.
  always_comb begin
    stepped = way_step(LVS_MAX_IDXW'(ptr), NUM_WAYS);
    start   = fill_ok ? stepped[IDXW-1:0] : ptr;
  end

  // R1, R5: one pointer for the whole cache; rests on the accepted victim.
  always_ff @(posedge clk) begin
    if (!rst_n)      ptr <= '0;
    else if (accept) ptr <= sel;
    else             ptr <= start;
  end

  // R5
  a_r5_take_victim: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> ptr == $past(sel));

  // R6
  a_r6_step_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_ok && !accept) |=>
      ((int'(ptr) == int'($past(ptr)) + 1) ||
       (ptr == '0 && int'($past(ptr)) == int'(NUM_WAYS) - 1)));

  // R7, R10
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!fill_ok && !accept) |=> $stable(ptr));

endmodule

// File: rtl/lockaware_victim_sel.sv
module lockaware_victim_sel
  import lvs_pkg::*;
#(
  parameter int unsigned NUM_WAYS = 4,
  localparam int unsigned IDXW    = $clog2(NUM_WAYS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                miss_req,
  input  logic                miss_is_data,
  input  logic [NUM_WAYS-1:0] insn_alloc_dis,
  input  logic [NUM_WAYS-1:0] data_alloc_dis,
  input  logic [NUM_WAYS-1:0] set_lock,
  input  logic                fill_done,
  input  logic                fill_err,
  output logic [IDXW-1:0]     victim_way,
  output logic                victim_vld,
  output logic                none_avail
);

  // R11: only 4-way and 8-way builds are supported.
  initial begin
    a_r11_ways: assert (NUM_WAYS == 4 || NUM_WAYS == 8)
      else $error("NUM_WAYS must be 4 or 8");
  end

  acc_kind_e           kind;
  logic [NUM_WAYS-1:0] elig_mask;
  logic [IDXW-1:0]     ptr_q;
  logic [IDXW-1:0]     search_start;
  logic                hit_found;
  logic [IDXW-1:0]     hit_way;
  logic                fill_ok;
  logic                miss_take;

  assign kind    = miss_is_data ? ACC_DATA : ACC_INSN;
  // R10: an error flag means nothing without the completion strobe.
  assign fill_ok = fill_done & ~fill_err;

  lvs_elig #(.NUM_WAYS(NUM_WAYS)) elig_i (
    .kind     (kind),
    .insn_dis (insn_alloc_dis),
    .data_dis (data_alloc_dis),
    .lock     (set_lock),
    .elig     (elig_mask)
  );

  lvs_search #(.NUM_WAYS(NUM_WAYS)) search_i (
    .elig  (elig_mask),
    .start (search_start),
    .found (hit_found),
    .way   (hit_way)
  );

  assign miss_take = miss_req & hit_found;

  lvs_ptr #(.NUM_WAYS(NUM_WAYS)) ptr_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .fill_ok (fill_ok),
    .accept  (miss_take),
    .sel     (hit_way),
    .ptr     (ptr_q),
    .start   (search_start)
  );

  // R9: results are valid in the cycle of the request.
  assign victim_vld = miss_take;
  assign none_avail = miss_req & ~hit_found;
  assign victim_way = hit_way;

  // R9
  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !miss_req |-> (!victim_vld && !none_avail));

  // R9
  a_r9_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(victim_vld && none_avail));

  // R3
  a_r3_victim_allowed: assert property (@(posedge clk) disable iff (!rst_n)
    victim_vld |-> (!set_lock[victim_way] &&
                    !(miss_is_data ? data_alloc_dis[victim_way]
                                   : insn_alloc_dis[victim_way])));

  // R4
  a_r4_none_empty: assert property (@(posedge clk) disable iff (!rst_n)
    none_avail |-> ($countones(elig_mask) == 0));

endmodule

// File: tb/lockaware_victim_sel_tb.sv
`timescale 1ns/1ps
module lockaware_victim_sel_tb_top;

  localparam int unsigned W  = 4;
  localparam int unsigned IW = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          miss_req = 1'b0;
  logic          miss_is_data = 1'b0;
  logic [W-1:0]  insn_alloc_dis = '0;
  logic [W-1:0]  data_alloc_dis = '0;
  logic [W-1:0]  set_lock = '0;
  logic          fill_done = 1'b0;
  logic          fill_err = 1'b0;
  logic [IW-1:0] victim_way;
  logic          victim_vld;
  logic          none_avail;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  lockaware_victim_sel #(.NUM_WAYS(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .miss_req(miss_req), .miss_is_data(miss_is_data),
    .insn_alloc_dis(insn_alloc_dis), .data_alloc_dis(data_alloc_dis),
    .set_lock(set_lock), .fill_done(fill_done), .fill_err(fill_err),
    .victim_way(victim_way), .victim_vld(victim_vld), .none_avail(none_avail)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // One cycle: drive at the falling edge, sample the combinational outputs 2 ns later.
  task automatic cyc(input bit m, input bit d, input logic [W-1:0] idis,
                     input logic [W-1:0] ddis, input logic [W-1:0] lk,
                     input bit fd, input bit fe,
                     input bit e_vld, input bit e_none, input int e_way,
                     input string req);
    @(negedge clk);
    miss_req = m; miss_is_data = d; insn_alloc_dis = idis;
    data_alloc_dis = ddis; set_lock = lk; fill_done = fd; fill_err = fe;
    #2;
    chk(req, "victim_vld", int'(victim_vld), int'(e_vld));
    chk(req, "none_avail", int'(none_avail), int'(e_none));
    if (e_vld) chk(req, "victim_way", int'(victim_way), e_way);
  endtask

  task automatic t_reset_and_idle();
    cyc(0,0,4'b0000,4'b0000,4'b0000,0,0, 0,0,0, "R9");  // idle: both flags low
    cyc(1,0,4'b0000,4'b0000,4'b0000,0,0, 1,0,0, "R1");  // first miss -> way 0
  endtask

  task automatic t_advance_and_wrap();
    cyc(0,0,4'b0000,4'b0000,4'b0000,1,0, 0,0,0, "R6");  // ptr 0 -> 1
    cyc(1,0,4'b0000,4'b0000,4'b0000,0,0, 1,0,1, "R6");
    cyc(0,0,4'b0000,4'b0000,4'b0000,1,0, 0,0,0, "R6");  // ptr 1 -> 2
    cyc(1,0,4'b0000,4'b0000,4'b0100,0,0, 1,0,3, "R2");  // way 2 locked -> 3
    cyc(0,0,4'b0000,4'b0000,4'b0000,1,0, 0,0,0, "R6");  // ptr 3 -> 0 wrap
    cyc(1,0,4'b0000,4'b0000,4'b0000,0,0, 1,0,0, "R6");
    cyc(0,0,4'b0000,4'b0000,4'b0000,1,0, 0,0,0, "R6");  // ptr 0 -> 1
  endtask

  task automatic t_type_masks();
    cyc(1,0,4'b0010,4'b0100,4'b0000,0,0, 1,0,2, "R3");  // insn: way 1 barred
    cyc(1,1,4'b0010,4'b0100,4'b0000,0,0, 1,0,3, "R3");  // data: way 2 barred
    cyc(1,0,4'b0000,4'b0000,4'b1000,0,0, 1,0,0, "R2");  // wrap search 3 -> 0
  endtask

  task automatic t_none();
    cyc(1,0,4'b0000,4'b0000,4'b1111,0,0, 0,1,0, "R4");
    cyc(1,1,4'b0000,4'b1111,4'b0000,0,0, 0,1,0, "R4");  // data all barred
    cyc(1,0,4'b0000,4'b1111,4'b0000,0,0, 1,0,0, "R3");  // insn unaffected
  endtask

  task automatic t_errors();
    cyc(0,0,4'b0000,4'b0000,4'b0000,1,1, 0,0,0, "R7");
    cyc(1,0,4'b0000,4'b0000,4'b0000,0,0, 1,0,0, "R7");  // same way again
    cyc(0,0,4'b0000,4'b0000,4'b0000,0,1, 0,0,0, "R10");
    cyc(1,0,4'b0000,4'b0000,4'b0000,0,0, 1,0,0, "R10");
  endtask

  task automatic t_coincident();
    cyc(1,0,4'b0000,4'b0000,4'b0000,1,0, 1,0,1, "R8");  // start 1
    cyc(1,0,4'b0000,4'b0000,4'b1110,1,0, 1,0,0, "R8");  // start 2, wraps to 0
    cyc(1,0,4'b0000,4'b0000,4'b1111,1,0, 0,1,0, "R8");  // none, ptr still 0 -> 1
    cyc(1,0,4'b0000,4'b0000,4'b0000,0,0, 1,0,1, "R8");
    cyc(1,0,4'b0000,4'b0000,4'b1111,0,0, 0,1,0, "R4");  // ptr stays 1
    cyc(1,0,4'b0000,4'b0000,4'b0000,0,0, 1,0,1, "R4");
    cyc(1,0,4'b0000,4'b0000,4'b0010,0,0, 1,0,2, "R5");  // ptr now 2
    cyc(1,0,4'b0000,4'b0000,4'b0000,0,0, 1,0,2, "R5");
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog R1: actual hung expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset_and_idle();
    t_advance_and_wrap();
    t_type_masks();
    t_none();
    t_errors();
    t_coincident();
    @(negedge clk);
    miss_req = 1'b0; fill_done = 1'b0; fill_err = 1'b0;
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule